// File: doc/BRIEF.md
# Device Run/Stop and Context Save/Restore Control

This block holds the run and keep-connect controls of a USB device controller and turns them into a connect-enable signal for the lower layer. Software starts the controller by setting the run bit. Clearing the run bit makes the device disconnect from the host, unless keep-connect is set. After a real disconnect, a reconnect waits until a minimum off time has passed. That time is longer in SuperSpeed mode than in the high/full/low-speed modes. A run request that arrives before the wait ends is held. The run bit reads back as 1 at once, but connect is not asserted until the wait is over.

The same control word carries three command bits that clear themselves. The save and restore commands raise a busy flag, which stays up until the context engine pulses its completion input. The soft-reset command puts every field and every status back to its power-on value. All three command bits read as 0. The halted status reports that the controller has stopped: the run bit is clear, the core is idle, and the lower layer has confirmed any disconnect that was pending.

Top module: `devctl_runstop`

## Requirements
- R1: After reset, connect_en, halted (with core_idle low), save_busy and restore_busy are 0, and rd_data is 0.
- R2: Control word layout: bit 0 run, bit 1 keep-connect, bit 2 save command, bit 3 restore command, bit 4 soft reset. When no off-time wait is running, a write that sets run makes connect_en 1 two clock edges after the write edge. connect_en never rises unless run is set.
- R3: If run is written 0 while keep-connect is 0, connect_en falls one edge after the write edge. It stays 0 for as long as run stays 0.
- R4: While keep-connect is 1, clearing run leaves connect_en at 1.
- R5: After a disconnect, halted rises only once run is 0, core_idle is 1, and a disc_done pulse has been seen. It rises one edge after the last of these conditions is met. It falls one edge after run is set again.
- R6: A disconnect starts a wait of CYC_PER_TICK × HS_OFF_TICKS cycles, or CYC_PER_TICK × SS_OFF_TICKS cycles when ss_mode is 1. The ss_mode value at the disconnect selects which. If run is set again during the wait, run reads as 1, and connect_en rises the second edge after the wait ends. Measured from the write edge that cleared run, this is edge wait+2.
- R7: A write with the save bit set makes save_busy 1 right after the write edge. save_busy returns to 0 one edge after a save_done pulse. If a save write and save_done fall in the same cycle, save_busy stays 1.
- R8: The restore bit, restore_busy and restore_done follow the R7 rules on their own, without affecting the save path.
- R9: rd_data shows run and keep-connect in bits 0 and 1. Bits 2, 3 and 4 always read as 0.
- R10: A write with the soft-reset bit set is held as a one-cycle pulse. The other fields of that write are ignored. One edge later, run, keep-connect, both busy flags and connect_en are 0, and any off-time wait is cancelled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 5 | Control word write data |
| rd_data | output | 5 | Control word readback |
| core_idle | input | 1 | Core has no activity in progress |
| disc_done | input | 1 | Pulse: lower layer has finished disconnecting |
| save_done | input | 1 | Pulse: context save finished |
| restore_done | input | 1 | Pulse: context restore finished |
| ss_mode | input | 1 | 1 when operating at SuperSpeed |
| connect_en | output | 1 | Device presents a connection to the host |
| halted | output | 1 | Controller is stopped |
| save_busy | output | 1 | Save in progress |
| restore_busy | output | 1 | Restore in progress |

## Verification
The assertions check, on every cycle, the local cause-and-effect rules: connect only rises with run set and the wait finished, an unkept connection drops one edge after run clears, keep-connect holds the link, halted rises only from an idle stopped core, a busy flag follows its set and done inputs, and soft reset lasts one cycle and clears the state. The bench scenarios cover what needs a longer time span or an exact count. They measure the off-time wait in both speed modes, and they show that halted waits for disc_done. They also cover the command bits reading as zero and a soft reset cancelling a wait, so that a reconnect follows at once.

// File: rtl/devctl_pkg.sv
package devctl_pkg;

  localparam int unsigned CTL_W     = 5;
  localparam int unsigned F_RUN     = 0;
  localparam int unsigned F_KEEP    = 1;
  localparam int unsigned F_SAVE    = 2;
  localparam int unsigned F_RESTORE = 3;
  localparam int unsigned F_SRST    = 4;

  localparam int unsigned CTX_N     = 2;
  localparam int unsigned CTX_SAVE  = 0;
  localparam int unsigned CTX_REST  = 1;

  // Number of ticks the link must stay off for the given speed mode.
  function automatic int unsigned off_ticks(input logic ss,
                                            input int unsigned ss_t,
                                            input int unsigned hs_t);
    return ss ? ss_t : hs_t;
  endfunction

  function automatic int unsigned max_u(input int unsigned a,
                                        input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/devctl_offtimer.sv
module devctl_offtimer import devctl_pkg::*; #(
  parameter int unsigned CYC_PER_TICK = 250000,
  parameter int unsigned SS_TICKS     = 30,
  parameter int unsigned HS_TICKS     = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic start,
  input  logic ss_mode,
  output logic off_ok
);
  localparam int unsigned MAXT = max_u(SS_TICKS, HS_TICKS);
  localparam int unsigned TW   = $clog2(MAXT + 1);
  localparam int unsigned CW   = $clog2(CYC_PER_TICK) + 1;

  logic [CW-1:0] cyc_q;
  logic [TW-1:0] tk_q;
  logic [TW-1:0] lim_q;
  logic          ok_q;
  logic          tick;
  logic          wait_end;

  // Named events for the checks below.
  assign tick     = !ok_q && (cyc_q == CW'(CYC_PER_TICK - 1));
  assign wait_end = tick && ((tk_q + TW'(1)) == lim_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q  <= 1'b1;
      cyc_q <= '0;
      tk_q  <= '0;
      lim_q <= '0;
    end else if (clr) begin
      ok_q  <= 1'b1;
      cyc_q <= '0;
      tk_q  <= '0;
      lim_q <= '0;
    end else if (start) begin
      ok_q  <= 1'b0;
      cyc_q <= '0;
      tk_q  <= '0;
      lim_q <= TW'(off_ticks(ss_mode, SS_TICKS, HS_TICKS));
    end else if (!ok_q) begin
      if (tick) begin
        cyc_q <= '0;
        tk_q  <= tk_q + TW'(1);
        if (wait_end) ok_q <= 1'b1;
      end else begin
        cyc_q <= cyc_q + CW'(1);
      end
    end
  end

  assign off_ok = ok_q;

  // R6: while waiting, the tick count stays below the latched limit
  p_tick_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ok_q |-> (tk_q < lim_q));

  // R6: the wait only ends on a tick or through soft reset
  p_wait_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok_q) |-> ($past(wait_end) || $past(clr)));

endmodule

// File: rtl/devctl_cmd_track.sv
module devctl_cmd_track (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic set,
  input  logic done,
  output logic busy
);
  logic busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_q <= 1'b0;
    else if (clr)    busy_q <= 1'b0;
    else if (set)    busy_q <= 1'b1;
    else if (done)   busy_q <= 1'b0;
  end

  assign busy = busy_q;

  // R7 (save instance) / R8 (restore instance): a command wins over completion
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (set && !clr) |=> busy_q);

  // R7 / R8: completion without a new command clears the flag
  p_done_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !set) |=> !busy_q);

endmodule

// File: rtl/devctl_link.sv
module devctl_link (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic keep,
  input  logic off_ok,
  input  logic core_idle,
  input  logic disc_done,
  output logic conn,
  output logic halted,
  output logic fall_evt
);
  logic conn_q;
  logic conn_d;
  logic disc_pend_q;
  logic halted_q;
  logic halt_cond;

  // Connect when running and the off time is over; keep-connect holds a live link.
  assign conn_d    = (run && off_ok) || (conn_q && keep);
  assign fall_evt  = conn_q && !conn_d && !clr;
  assign halt_cond = !run && core_idle && !disc_pend_q && !(conn_q && !keep);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conn_q      <= 1'b0;
      disc_pend_q <= 1'b0;
      halted_q    <= 1'b0;
    end else if (clr) begin
      conn_q      <= 1'b0;
      disc_pend_q <= 1'b0;
      halted_q    <= 1'b0;
    end else begin
      conn_q   <= conn_d;
      halted_q <= halt_cond;
      if (fall_evt)       disc_pend_q <= 1'b1;
      else if (disc_done) disc_pend_q <= 1'b0;
    end
  end

  assign conn   = conn_q;
  assign halted = halted_q;

  p_conn_needs_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conn_q) |-> $past(run && off_ok));

  p_drop_unkept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (conn_q && !run && !keep) |=> !conn_q);

  p_keep_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (conn_q && keep && !clr) |=> conn_q);

  p_halt_needs_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted_q) |-> $past(core_idle && !run && !disc_pend_q));

endmodule

// File: rtl/devctl_runstop.sv
module devctl_runstop import devctl_pkg::*; #(
  parameter int unsigned CYC_PER_TICK = 250000,
  parameter int unsigned SS_OFF_TICKS = 30,
  parameter int unsigned HS_OFF_TICKS = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  output logic [CTL_W-1:0] rd_data,
  input  logic             core_idle,
  input  logic             disc_done,
  input  logic             save_done,
  input  logic             restore_done,
  input  logic             ss_mode,
  output logic             connect_en,
  output logic             halted,
  output logic             save_busy,
  output logic             restore_busy
);
  logic run_q;
  logic keep_q;
  logic srst_q;
  logic wr_ok;
  logic srst_req;
  logic field_wr;
  logic off_ok;
  logic fall_evt;
  logic [CTX_N-1:0] ctx_set;
  logic [CTX_N-1:0] ctx_done;
  logic [CTX_N-1:0] ctx_busy;

  // Writes during the soft-reset pulse are dropped; a soft-reset write ignores its other fields.
  assign wr_ok    = wr_en && !srst_q;
  assign srst_req = wr_ok && wr_data[F_SRST];
  assign field_wr = wr_ok && !wr_data[F_SRST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      keep_q <= 1'b0;
      srst_q <= 1'b0;
    end else if (srst_q) begin
      run_q  <= 1'b0;
      keep_q <= 1'b0;
      srst_q <= 1'b0;
    end else begin
      srst_q <= srst_req;
      if (field_wr) begin
        run_q  <= wr_data[F_RUN];
        keep_q <= wr_data[F_KEEP];
      end
    end
  end

  always_comb begin
    rd_data         = '0;
    rd_data[F_RUN]  = run_q;
    rd_data[F_KEEP] = keep_q;
  end

  devctl_offtimer #(
    .CYC_PER_TICK (CYC_PER_TICK),
    .SS_TICKS     (SS_OFF_TICKS),
    .HS_TICKS     (HS_OFF_TICKS)
  ) u_off (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (srst_q),
    .start   (fall_evt),
    .ss_mode (ss_mode),
    .off_ok  (off_ok)
  );

  devctl_link u_link (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (srst_q),
    .run       (run_q),
    .keep      (keep_q),
    .off_ok    (off_ok),
    .core_idle (core_idle),
    .disc_done (disc_done),
    .conn      (connect_en),
    .halted    (halted),
    .fall_evt  (fall_evt)
  );

  assign ctx_set[CTX_SAVE]  = field_wr && wr_data[F_SAVE];
  assign ctx_set[CTX_REST]  = field_wr && wr_data[F_RESTORE];
  assign ctx_done[CTX_SAVE] = save_done;
  assign ctx_done[CTX_REST] = restore_done;

  for (genvar c = 0; c < CTX_N; c++) begin : g_ctx
    devctl_cmd_track u_trk (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (srst_q),
      .set   (ctx_set[c]),
      .done  (ctx_done[c]),
      .busy  (ctx_busy[c])
    );
  end

  assign save_busy    = ctx_busy[CTX_SAVE];
  assign restore_busy = ctx_busy[CTX_REST];

  p_srst_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> !srst_q);

  p_srst_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (!run_q && !keep_q && !connect_en && !save_busy && !restore_busy));

endmodule

// File: tb/sim_devctl_runstop.sv
`timescale 1ns/1ps
module sim_devctl_runstop;
  localparam int unsigned CPT  = 4;
  localparam int unsigned SS_T = 30;
  localparam int unsigned HS_T = 10;

  localparam logic [4:0] B_RUN  = 5'b00001;
  localparam logic [4:0] B_KEEP = 5'b00010;
  localparam logic [4:0] B_SAVE = 5'b00100;
  localparam logic [4:0] B_REST = 5'b01000;
  localparam logic [4:0] B_SRST = 5'b10000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [4:0] wr_data = '0;
  logic [4:0] rd_data;
  logic       core_idle = 1'b0;
  logic       disc_done = 1'b0;
  logic       save_done = 1'b0;
  logic       restore_done = 1'b0;
  logic       ss_mode = 1'b0;
  logic       connect_en, halted, save_busy, restore_busy;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  devctl_runstop #(
    .CYC_PER_TICK (CPT),
    .SS_OFF_TICKS (SS_T),
    .HS_OFF_TICKS (HS_T)
  ) u0 (
    .clk, .rst_n, .wr_en, .wr_data, .rd_data, .core_idle, .disc_done,
    .save_done, .restore_done, .ss_mode, .connect_en, .halted,
    .save_busy, .restore_busy
  );

  // Edges from the run-clearing write edge to connect_en high (R6).
  function automatic int reconnect_edges(input logic ss);
    int ticks;
    ticks = ss ? SS_T : HS_T;
    return CPT * ticks + 2;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Returns at the falling edge that follows the write edge.
  task automatic wr(input logic [4:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_disc();
    @(negedge clk); disc_done = 1'b1;
    @(negedge clk); disc_done = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 connect_en", connect_en, 0);
    chk("R1 halted", halted, 0);
    chk("R1 save_busy", save_busy, 0);
    chk("R1 restore_busy", restore_busy, 0);
    chk("R1 rd_data", rd_data, 0);
  endtask

  task automatic t_connect();
    wr(B_RUN);
    chk("R2 connect one edge after write", connect_en, 0);
    @(negedge clk);
    chk("R2 connect two edges after write", connect_en, 1);
    chk("R9 run reads back", rd_data, B_RUN);
  endtask

  task automatic t_disc_halt();
    wr(5'b0);
    @(negedge clk);
    chk("R3 connect dropped", connect_en, 0);
    core_idle = 1'b1;
    idle(5);
    chk("R5 no halt before disc_done", halted, 0);
    pulse_disc();
    @(negedge clk);
    chk("R5 halted after disc_done", halted, 1);
    idle(60);
    chk("R3 stays disconnected while run is 0", connect_en, 0);
    wr(B_RUN);
    @(negedge clk);
    chk("R5 halted clears on run", halted, 0);
    chk("R2 reconnect after wait", connect_en, 1);
    core_idle = 1'b0;
  endtask

  task automatic t_offtime(input logic ss);
    int first;
    ss_mode = ss;
    first = -1;
    @(negedge clk); wr_en = 1'b1; wr_data = 5'b0;
    @(negedge clk); wr_data = B_RUN;
    for (int i = 1; i < 300; i++) begin
      @(negedge clk);
      if (i == 1) wr_en = 1'b0;
      if (i == 5) begin
        chk("R6 pending run reads 1", rd_data, B_RUN);
        chk("R6 no connect while waiting", connect_en, 0);
      end
      if (connect_en && first < 0) first = i;
    end
    chk(ss ? "R6 SuperSpeed reconnect edge" : "R6 high-speed reconnect edge",
        first, reconnect_edges(ss));
    pulse_disc();
    ss_mode = 1'b0;
  endtask

  task automatic t_keep();
    wr(B_RUN | B_KEEP);
    @(negedge clk);
    chk("R4 connected with keep", connect_en, 1);
    wr(B_KEEP);
    idle(4);
    chk("R4 keep holds link with run clear", connect_en, 1);
    chk("R9 keep reads back", rd_data, B_KEEP);
    wr(5'b0);
    @(negedge clk);
    chk("R3 drop once keep clears", connect_en, 0);
    pulse_disc();
    idle(50);
  endtask

  task automatic t_ctx(input logic rest);
    string nm;
    logic [4:0] cmd;
    nm  = rest ? "R8" : "R7";
    cmd = rest ? B_REST : B_SAVE;
    wr(cmd);
    chk({nm, " busy set after write"}, rest ? restore_busy : save_busy, 1);
    chk({nm, " other channel untouched"}, rest ? save_busy : restore_busy, 0);
    chk("R9 command bit reads 0", rd_data, 0);
    idle(3);
    chk({nm, " busy holds"}, rest ? restore_busy : save_busy, 1);
    @(negedge clk); if (rest) restore_done = 1'b1; else save_done = 1'b1;
    @(negedge clk); restore_done = 1'b0; save_done = 1'b0;
    chk({nm, " busy cleared by done"}, rest ? restore_busy : save_busy, 0);
    @(negedge clk);
    wr_en = 1'b1; wr_data = cmd;
    if (rest) restore_done = 1'b1; else save_done = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; restore_done = 1'b0; save_done = 1'b0;
    chk({nm, " command wins over done"}, rest ? restore_busy : save_busy, 1);
    @(negedge clk); if (rest) restore_done = 1'b1; else save_done = 1'b1;
    @(negedge clk); restore_done = 1'b0; save_done = 1'b0;
    chk({nm, " busy cleared again"}, rest ? restore_busy : save_busy, 0);
  endtask

  task automatic t_srst();
    wr(B_RUN | B_KEEP);
    @(negedge clk);
    chk("R10 setup connected", connect_en, 1);
    wr(B_RUN | B_KEEP | B_SAVE);
    chk("R10 setup save busy", save_busy, 1);
    wr(B_SRST);
    chk("R10 fields kept during pulse", rd_data, B_RUN | B_KEEP);
    @(negedge clk);
    chk("R10 fields cleared", rd_data, 0);
    chk("R10 connect cleared", connect_en, 0);
    chk("R10 save busy cleared", save_busy, 0);
    wr(B_RUN);
    @(negedge clk);
    chk("R10 no off wait after soft reset", connect_en, 1);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_connect();
    t_disc_halt();
    t_offtime(1'b0);
    t_offtime(1'b1);
    t_keep();
    t_ctx(1'b0);
    t_ctx(1'b1);
    t_srst();
    finished = 1'b1;
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      finish_run();
    end
  end

endmodule